// File: doc/BRIEF.md
# ACPI Power-Management Event and Timer Block

This block holds the fixed power-management event registers of a system controller: a status register, an enable register and a control register, plus a free-running power-management timer. Software reaches them through a small I/O window whose base address comes from a configuration value and whose decode can be switched off as a whole. Hardware event inputs for the real-time clock alarm, the power button and a global event raise status bits. Any status bit that is also enabled drives a level system-control interrupt (SCI) until software clears it by writing ones to the status register.

The timer counts tick-enable pulses from an external time base. Whenever its top bit changes, the timer-overflow status bit is set, so software can extend the count in firmware. Writing the control register with the suspend-enable bit set and a suspend type of zero produces a one-cycle soft-power-off request toward the platform's power sequencer. The suspend-enable bit itself is never kept.

Top module: `pm_event_timer`

## Requirements
- R1: The window covers 64 bytes at base `cfg_base[15:0] & 16'hFFC0`. It decodes only while `cfg_enable[0]` is 1. Outside the window, or while decode is off, reads return 0 and writes change nothing.
- R2: Register selection uses only `io_addr[3:0]`. A 16-bit access (`io_size32`=0) reaches status at 0x0, enable at 0x2 and control at 0x4. A 32-bit read at 0x8 returns the timer. Every other offset or size reads 0, and 32-bit writes have no effect.
- R3: A 16-bit write to status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A rising edge on `ev_rtc`, `ev_pwrbtn` or `ev_global` sets status bit 10, 8 or 5 respectively. An input held high sets its bit only once. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R5: `sci` is a registered output. In each cycle it equals the OR of (status AND enable AND 16'h0521), as held one cycle earlier.
- R6: The timer is `TMR_W` bits wide (24 by default). It advances by one on each cycle with `tick` high and wraps from all-ones to 0. A timer read is zero-extended to 32 bits.
- R7: Status bit 0 (timer overflow) is set on every tick that changes the timer's top bit, both at the half-way count and at the wrap.
- R8: A control write stores the data with bit 13 forced to 0. If bit 13 is 1 and bits 11:10 are 0, `poweroff_req` is high for exactly the one cycle after the write. Other suspend types produce no pulse.
- R9: After reset, status, enable, control and timer read as 0, and `sci` and `poweroff_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Configured window base; bits 15:6 are used |
| cfg_enable | input | 8 | Decode enable byte; bit 0 enables the window |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_size32 | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| io_wdata | input | 32 | Write data; 16-bit accesses use bits 15:0 |
| io_rdata | output | 32 | Read data, combinational, 0 when not selected |
| tick | input | 1 | Timer advance enable |
| ev_rtc | input | 1 | RTC alarm event |
| ev_pwrbtn | input | 1 | Power button event |
| ev_global | input | 1 | Global event |
| sci | output | 1 | Level system-control interrupt |
| poweroff_req | output | 1 | One-cycle soft-power-off request |

## Verification
A status bit that is stuck or wrongly cleared shows up on the very next read of the status offset. It also shows up on `sci` one cycle later whenever that bit is enabled. A timer that drifts or misses its top-bit transition shows up in the 32-bit timer read as a count that differs from the number of ticks applied, and as an overflow flag that rises at the wrong tick. A wrong suspend decode shows up as a missing, doubled or spurious `poweroff_req` in the cycle after the control write.

// File: rtl/pm_pkg.sv
package pm_pkg;

  localparam int unsigned REG_W     = 16;
  localparam int unsigned NUM_EV    = 3;
  localparam logic [15:0] WIN_MASK  = 16'hFFC0;
  localparam logic [REG_W-1:0] SCI_MASK = 16'h0521;
  localparam int unsigned BIT_TMROVF = 0;
  localparam int unsigned BIT_SUSEN  = 13;

  // status bit raised by each event input: rtc, power button, global
  localparam int unsigned EV_POS [NUM_EV] = '{10, 8, 5};

  localparam logic [3:0] OFF_STS = 4'h0;
  localparam logic [3:0] OFF_EN  = 4'h2;
  localparam logic [3:0] OFF_CTL = 4'h4;
  localparam logic [3:0] OFF_TMR = 4'h8;

  typedef enum logic [2:0] {
    RD_NONE, RD_STS, RD_EN, RD_CTL, RD_TMR
  } rd_sel_e;

  function automatic logic win_hit(input logic [15:0] addr, input logic [31:0] base);
    return (addr & WIN_MASK) == (base[15:0] & WIN_MASK);
  endfunction

  function automatic logic sci_level(input logic [REG_W-1:0] sts, input logic [REG_W-1:0] en);
    return |(sts & en & SCI_MASK);
  endfunction

  function automatic logic soft_off(input logic [REG_W-1:0] wdata);
    return wdata[BIT_SUSEN] && (wdata[11:10] == 2'b00);
  endfunction

endpackage

// File: rtl/pm_decode.sv
module pm_decode
  import pm_pkg::*;
(
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_size32,
  input  logic [31:0] cfg_base,
  input  logic        decode_on,
  output logic        sts_wr,
  output logic        en_wr,
  output logic        ctl_wr,
  output rd_sel_e     rd_sel
);
  logic       hit;
  logic [3:0] off;

  assign hit = decode_on && win_hit(io_addr, cfg_base);
  assign off = io_addr[3:0];

  always_comb begin
    sts_wr = 1'b0;
    en_wr  = 1'b0;
    ctl_wr = 1'b0;
    rd_sel = RD_NONE;
    if (hit && io_wr && !io_size32) begin
      sts_wr = (off == OFF_STS);
      en_wr  = (off == OFF_EN);
      ctl_wr = (off == OFF_CTL);
    end
    if (hit && io_rd) begin
      if (io_size32) begin
        if (off == OFF_TMR) rd_sel = RD_TMR;
      end else begin
        case (off)
          OFF_STS: rd_sel = RD_STS;
          OFF_EN:  rd_sel = RD_EN;
          OFF_CTL: rd_sel = RD_CTL;
          default: rd_sel = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] count,
  output logic             ovf_evt
);
  // top bit changes exactly when all lower bits are ones and a tick arrives
  assign ovf_evt = tick && (&count[TMR_W-2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + TMR_W'(1);
  end
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr,
  input  logic             en_wr,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic             ovf_evt,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en,
  output logic [REG_W-1:0] ctl,
  output logic [REG_W-1:0] set_vec,
  output logic             sci,
  output logic             poweroff_req
);
  logic [NUM_EV-1:0] ev_q;
  logic [REG_W-1:0]  clr_vec;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_EV; i++)
      set_vec[EV_POS[i]] = ev_in[i] && !ev_q[i];
    set_vec[BIT_TMROVF] = ovf_evt;
  end

  assign clr_vec = sts_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q         <= '0;
      sts          <= '0;
      en           <= '0;
      ctl          <= '0;
      sci          <= 1'b0;
      poweroff_req <= 1'b0;
    end else begin
      ev_q         <= ev_in;
      sts          <= (sts & ~clr_vec) | set_vec;
      if (en_wr)  en  <= wdata;
      if (ctl_wr) ctl <= wdata & ~(REG_W'(1) << BIT_SUSEN);
      sci          <= sci_level(sts, en);
      poweroff_req <= ctl_wr && soft_off(wdata);
    end
  end
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
  import pm_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_enable,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_size32,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  input  logic        tick,
  input  logic        ev_rtc,
  input  logic        ev_pwrbtn,
  input  logic        ev_global,
  output logic        sci,
  output logic        poweroff_req
);
  logic             sts_wr, en_wr, ctl_wr;
  rd_sel_e          rd_sel;
  logic [TMR_W-1:0] tmr_count;
  logic             ovf_evt;
  logic [REG_W-1:0] sts_q, en_q, ctl_q, set_vec;

  pm_decode u_decode (
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_size32 (io_size32),
    .cfg_base  (cfg_base),
    .decode_on (cfg_enable[0]),
    .sts_wr    (sts_wr),
    .en_wr     (en_wr),
    .ctl_wr    (ctl_wr),
    .rd_sel    (rd_sel)
  );

  pm_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .count   (tmr_count),
    .ovf_evt (ovf_evt)
  );

  pm_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sts_wr       (sts_wr),
    .en_wr        (en_wr),
    .ctl_wr       (ctl_wr),
    .wdata        (io_wdata[REG_W-1:0]),
    .ev_in        ({ev_global, ev_pwrbtn, ev_rtc}),
    .ovf_evt      (ovf_evt),
    .sts          (sts_q),
    .en           (en_q),
    .ctl          (ctl_q),
    .set_vec      (set_vec),
    .sci          (sci),
    .poweroff_req (poweroff_req)
  );

  always_comb begin
    case (rd_sel)
      RD_STS:  io_rdata = 32'(sts_q);
      RD_EN:   io_rdata = 32'(en_q);
      RD_CTL:  io_rdata = 32'(ctl_q);
      RD_TMR:  io_rdata = 32'(tmr_count);
      default: io_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pm_event_timer_chk.sv
module pm_event_timer_chk #(
  parameter int unsigned TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_enable,
  input logic [31:0]      io_rdata,
  input logic             tick,
  input logic             sci,
  input logic             poweroff_req,
  input logic [TMR_W-1:0] tmr_count,
  input logic             ovf_evt,
  input logic [15:0]      sts_q,
  input logic [15:0]      en_q,
  input logic [15:0]      set_vec
);
  // R1
  decode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable[0] |-> io_rdata == 32'h0);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |set_vec |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

  // R5
  sci_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci == $past(|(sts_q & en_q & 16'h0521)));

  // R6
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tmr_count == $past(tmr_count) + TMR_W'(1));

  // R6
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tmr_count));

  // R7
  tmr_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> sts_q[0] && (tmr_count[TMR_W-1] != $past(tmr_count[TMR_W-1])));

  // R8
  poweroff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_req |=> !poweroff_req);
endmodule

bind pm_event_timer pm_event_timer_chk #(.TMR_W(TMR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .io_rdata     (io_rdata),
  .tick         (tick),
  .sci          (sci),
  .poweroff_req (poweroff_req),
  .tmr_count    (tmr_count),
  .ovf_evt      (ovf_evt),
  .sts_q        (sts_q),
  .en_q         (en_q),
  .set_vec      (set_vec)
);

// File: tb/pm_event_timer_tb.sv
`timescale 1ns/1ps
module pm_event_timer_tb;
  localparam int unsigned TW = 10;
  localparam int unsigned NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h0000_E001;
  logic [7:0]  cfg_enable = 8'h01;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, io_size32 = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        tick = 1'b0, ev_rtc = 1'b0, ev_pwrbtn = 1'b0, ev_global = 1'b0;
  logic        sci, poweroff_req;

  int n_chk = 0;
  int n_fail = 0;
  logic po1, po2;
  logic [31:0] rd_val;

  always #5 clk = ~clk;

  pm_event_timer #(.TMR_W(TW)) u_dut (.*);

  // op 0 = 16-bit write, 1 = read and compare; fields: op, size32, addr, data, expected
  localparam logic [82:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'hE002, 32'h0000_0521, 32'h0},            // R2 enable write
    {2'd1, 1'b0, 16'hE002, 32'h0,         32'h0000_0521},    // R2 enable read
    {2'd0, 1'b0, 16'hE004, 32'h0000_2C07, 32'h0},            // R8 type 3 write
    {2'd1, 1'b0, 16'hE004, 32'h0,         32'h0000_0C07},    // R8 bit 13 dropped
    {2'd1, 1'b0, 16'hE006, 32'h0,         32'h0},            // R2 unused offset
    {2'd0, 1'b1, 16'hE008, 32'hFFFF_FFFF, 32'h0},            // R2 32-bit write ignored
    {2'd1, 1'b1, 16'hE008, 32'h0,         32'h0},            // R2 timer at 0
    {2'd1, 1'b1, 16'hE002, 32'h0,         32'h0},            // R2 32-bit read off 2
    {2'd0, 1'b0, 16'hE012, 32'h0000_0100, 32'h0},            // R2 alias by low bits
    {2'd1, 1'b0, 16'hE002, 32'h0,         32'h0000_0100},    // R2 alias visible
    {2'd1, 1'b0, 16'hE042, 32'h0,         32'h0},            // R1 outside window
    {2'd0, 1'b0, 16'hE002, 32'h0000_0521, 32'h0}             // R2 restore enable
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [31:0] d, input logic s32);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_size32 = s32; io_wr = 1'b1;
    @(posedge clk); #1 po1 = poweroff_req;
    @(negedge clk);
    io_wr = 1'b0;
    @(posedge clk); #1 po2 = poweroff_req;
  endtask

  task automatic io_read(input logic [15:0] a, input logic s32, output logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_size32 = s32; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    io_read(16'hE000, 1'b0, rd_val); check("R9 status", rd_val, 32'h0);
    io_read(16'hE002, 1'b0, rd_val); check("R9 enable", rd_val, 32'h0);
    io_read(16'hE004, 1'b0, rd_val); check("R9 control", rd_val, 32'h0);
    io_read(16'hE008, 1'b1, rd_val); check("R9 timer", rd_val, 32'h0);
    check("R9 sci", {31'h0, sci}, 32'h0);
    check("R9 poweroff", {31'h0, poweroff_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][82:81] == 2'd0) begin
        io_write(VEC[i][79:64], VEC[i][63:32], VEC[i][80]);
      end else begin
        io_read(VEC[i][79:64], VEC[i][80], rd_val);
        check($sformatf("R2 vector %0d", i), rd_val, VEC[i][31:0]);
      end
    end

    // R4 power button edge, R5 sci follows
    @(negedge clk) ev_pwrbtn = 1'b1;
    @(negedge clk) ev_pwrbtn = 1'b0;
    io_read(16'hE000, 1'b0, rd_val); check("R4 pwrbtn status", rd_val, 32'h0000_0100);
    settle(); check("R5 sci asserted", {31'h0, sci}, 32'h1);

    // R3 clear, R5 sci drops
    io_write(16'hE000, 32'h0000_0100, 1'b0);
    io_read(16'hE000, 1'b0, rd_val); check("R3 clear pwrbtn", rd_val, 32'h0);
    settle(); check("R5 sci released", {31'h0, sci}, 32'h0);

    // R3 partial clear
    @(negedge clk) begin ev_rtc = 1'b1; ev_global = 1'b1; end
    @(negedge clk) begin ev_rtc = 1'b0; ev_global = 1'b0; end
    io_read(16'hE000, 1'b0, rd_val); check("R4 rtc and global", rd_val, 32'h0000_0420);
    io_write(16'hE000, 32'h0000_0020, 1'b0);
    io_read(16'hE000, 1'b0, rd_val); check("R3 partial clear", rd_val, 32'h0000_0400);
    io_write(16'hE000, 32'h0000_0400, 1'b0);

    // R4 set beats clear in the same cycle
    @(negedge clk);
    io_addr = 16'hE000; io_wdata = 32'h0000_0020; io_size32 = 1'b0; io_wr = 1'b1; ev_global = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; ev_global = 1'b0;
    io_read(16'hE000, 1'b0, rd_val); check("R4 set priority", rd_val, 32'h0000_0020);
    io_write(16'hE000, 32'h0000_0020, 1'b0);

    // R4 held level does not set again after clear
    @(negedge clk) ev_rtc = 1'b1;
    repeat (2) @(negedge clk);
    io_write(16'hE000, 32'h0000_0400, 1'b0);
    repeat (2) @(negedge clk);
    io_read(16'hE000, 1'b0, rd_val); check("R4 held level", rd_val, 32'h0);
    ev_rtc = 1'b0;

    // R8 soft power off
    io_write(16'hE004, 32'h0000_2000, 1'b0);
    check("R8 pulse high", {31'h0, po1}, 32'h1);
    check("R8 pulse one cycle", {31'h0, po2}, 32'h0);
    io_read(16'hE004, 1'b0, rd_val); check("R8 control stored", rd_val, 32'h0);
    io_write(16'hE004, 32'h0000_2400, 1'b0);
    check("R8 other type no pulse", {30'h0, po1, po2}, 32'h0);
    io_read(16'hE004, 1'b0, rd_val); check("R8 type kept", rd_val, 32'h0000_0400);

    // R1 decode disabled
    cfg_enable = 8'h00;
    io_read(16'hE002, 1'b0, rd_val); check("R1 read while off", rd_val, 32'h0);
    io_write(16'hE002, 32'h0000_0000, 1'b0);
    cfg_enable = 8'h01;
    io_read(16'hE002, 1'b0, rd_val); check("R1 write while off ignored", rd_val, 32'h0000_0521);

    // R6/R7 timer
    run_ticks(511);
    io_read(16'hE008, 1'b1, rd_val); check("R6 count 511", rd_val, 32'd511);
    io_read(16'hE000, 1'b0, rd_val); check("R7 no overflow yet", rd_val, 32'h0);
    run_ticks(1);
    io_read(16'hE000, 1'b0, rd_val); check("R7 half-way overflow", rd_val, 32'h1);
    settle(); check("R5 sci on overflow", {31'h0, sci}, 32'h1);
    io_write(16'hE000, 32'h0000_0001, 1'b0);
    io_read(16'hE000, 1'b0, rd_val); check("R3 overflow cleared", rd_val, 32'h0);
    run_ticks(512);
    io_read(16'hE008, 1'b1, rd_val); check("R6 wrap to zero", rd_val, 32'h0);
    io_read(16'hE000, 1'b0, rd_val); check("R7 wrap overflow", rd_val, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule